// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Aggregator

This block collects up to 64 level-sensitive device interrupt lines, plus one dedicated legacy line, into a single shared raw request register. Each of up to four CPUs has its own 64-bit enable mask over that raw register. A CPU's hard interrupt output is raised whenever any request it has enabled is pending.

Software reaches the block through a 64-bit register port. On this port it can program and read back each CPU's mask, read the raw register, and read each CPU's masked request view. Every request is answered exactly one cycle later. Accesses that are not a full 8 bytes wide, and accesses to unknown offsets, get an error response and change nothing.

Top module: `irq_fanout_mask`

## Requirements
- R1: Raw request bit n follows device line n: a level present on the line at clock edge k is visible in the raw register after edge k. Raw bits at or above the number of lines read as zero.
- R2: The legacy interrupt input is ORed into raw request bit 55.
- R3: cpu_irq[i] is high exactly when (mask_i AND raw) is nonzero. It is registered, so it changes one cycle after the raw register or the mask changes.
- R4: A full-width write stores all 64 bits of a CPU mask. The mask offsets are 0x200 (CPU0), 0x240 (CPU1), 0x600 (CPU2) and 0x640 (CPU3). A read at the same offset returns the stored mask.
- R5: A read at 0x280 (CPU0), 0x2C0 (CPU1), 0x680 (CPU2) or 0x6C0 (CPU3) returns that CPU's mask ANDed with the raw register.
- R6: A read at offset 0x300 returns the raw register.
- R7: Writes to the raw register offset or to a masked-view offset receive a non-error response and change no mask.
- R8: Any access whose byte count (req_bytes) is not 8 receives an error response and changes no state.
- R9: An access to any offset not listed in R4 to R6 receives an error response with zero read data.
- R10: After reset all masks and the raw register are zero, every cpu_irq output is low, and no response is pending.
- R11: Every accepted request produces exactly one response, one cycle later. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_lines | input | NUM_LINES | Level-sensitive device request lines |
| legacy_irq | input | 1 | Legacy interrupt, folded into raw bit 55 |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_bytes | input | 4 | Access width in bytes; only 8 is valid |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| cpu_irq | output | NUM_CPUS | Hard interrupt output per CPU |

## Verification
A register response is due on the first falling edge after the rising edge that samples the request. The bench driver pushes each expected response into a queue when it raises the request, and the monitor pops one entry at every falling edge where rsp_valid is high. A change on a device line reaches cpu_irq two rising edges later: one edge for the raw register and one for the output register. A mask write reaches cpu_irq one edge after its response appears. The bench samples cpu_irq only after those edges. One check also confirms that the output has not yet moved after the first edge.

// File: rtl/irqfan_pkg.sv
package irqfan_pkg;

   localparam int REG_W      = 64;
   localparam int LEGACY_POS = 55;
   localparam logic [3:0] FULL_BYTES = 4'd8;
   localparam logic [11:0] RAW_OFS   = 12'h300;

   // Mask offset per CPU: pairs of CPUs live in two separate pages
   function automatic logic [11:0] mask_ofs(input int cpu);
      logic [11:0] base;
      base = (cpu < 2) ? 12'h200 : 12'h600;
      return base + ((cpu % 2) != 0 ? 12'h040 : 12'h000);
   endfunction

   // Masked view sits 0x80 above the mask of the same CPU
   function automatic logic [11:0] view_ofs(input int cpu);
      return mask_ofs(cpu) + 12'h080;
   endfunction

endpackage

// File: rtl/irqfan_raw_tracker.sv
module irqfan_raw_tracker
   import irqfan_pkg::*;
#(
   parameter int NUM_LINES  = 64,
   parameter int LEGACY_BIT = LEGACY_POS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] dev_lines,
   input  logic                 legacy_irq,
   output logic [REG_W-1:0]     raw_q
);

   logic [REG_W-1:0] lines_ext;
   logic [REG_W-1:0] raw_next;

   generate
      if (NUM_LINES == REG_W) begin : g_full
         assign lines_ext = dev_lines;
      end else begin : g_part
         assign lines_ext = {{(REG_W-NUM_LINES){1'b0}}, dev_lines};
      end

      if (LEGACY_BIT >= 0 && LEGACY_BIT < REG_W) begin : g_legacy
         always_comb begin
            raw_next = lines_ext;
            raw_next[LEGACY_BIT] = lines_ext[LEGACY_BIT] | legacy_irq;
         end
      end else begin : g_nolegacy
         assign raw_next = lines_ext;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_next;
   end

endmodule

// File: rtl/irqfan_mask_bank.sv
module irqfan_mask_bank
   import irqfan_pkg::*;
#(
   parameter int NUM_CPUS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CPUS-1:0]           mask_we,
   input  logic [REG_W-1:0]              wdata,
   output logic [NUM_CPUS-1:0][REG_W-1:0] masks_q
);

   generate
      for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
         always_ff @(posedge clk) begin
            if (!rst_n)          masks_q[c] <= '0;
            else if (mask_we[c]) masks_q[c] <= wdata;
         end
      end
   endgenerate

   AST_ONE_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_we)); // R4

endmodule

// File: rtl/irqfan_reg_decode.sv
module irqfan_reg_decode
   import irqfan_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int ADDR_W   = 12
) (
   input  logic                           req_valid,
   input  logic                           req_write,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [3:0]                     req_bytes,
   input  logic [REG_W-1:0]               raw,
   input  logic [NUM_CPUS-1:0][REG_W-1:0] masks,
   output logic [NUM_CPUS-1:0]            mask_we,
   output logic                           err,
   output logic [REG_W-1:0]               rdata
);

   localparam int XW = ADDR_W - 12;

   logic [NUM_CPUS-1:0] hit_mask;
   logic [NUM_CPUS-1:0] hit_view;
   logic                hit_raw;
   logic                size_ok;
   logic                high_zero;
   logic [REG_W-1:0]    mux_data;

   generate
      if (XW > 0) begin : g_high
         assign high_zero = (req_addr[ADDR_W-1:12] == '0);
      end else begin : g_nohigh
         assign high_zero = 1'b1;
      end
   endgenerate

   assign size_ok = (req_bytes == FULL_BYTES);
   assign hit_raw = high_zero && (req_addr[11:0] == RAW_OFS);

   always_comb begin
      hit_mask = '0;
      hit_view = '0;
      mux_data = hit_raw ? raw : '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
         if (high_zero && req_addr[11:0] == mask_ofs(c)) begin
            hit_mask[c] = 1'b1;
            mux_data    = masks[c];
         end
         if (high_zero && req_addr[11:0] == view_ofs(c)) begin
            hit_view[c] = 1'b1;
            mux_data    = masks[c] & raw;
         end
      end
   end

   assign err     = !size_ok || !(hit_raw || (|hit_mask) || (|hit_view));
   assign rdata   = (err || req_write) ? '0 : mux_data;
   assign mask_we = (req_valid && req_write && size_ok) ? hit_mask : '0;

endmodule

// File: rtl/irq_fanout_mask.sv
module irq_fanout_mask
   import irqfan_pkg::*;
#(
   parameter int NUM_LINES  = 64,
   parameter int NUM_CPUS   = 4,
   parameter int ADDR_W     = 12,
   parameter int LEGACY_BIT = LEGACY_POS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] dev_lines,
   input  logic                 legacy_irq,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [3:0]           req_bytes,
   input  logic [63:0]          req_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [63:0]          rsp_rdata,
   output logic [NUM_CPUS-1:0]  cpu_irq
);

   generate
      if (NUM_CPUS < 1 || NUM_CPUS > 4) begin : g_bad_cpus
         $error("NUM_CPUS must be between 1 and 4");
      end
      if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_lines
         $error("NUM_LINES must be between 1 and 64");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must be at least 12");
      end
   endgenerate

   logic [REG_W-1:0]              raw_q;
   logic [NUM_CPUS-1:0][REG_W-1:0] masks_q;
   logic [NUM_CPUS-1:0]           mask_we;
   logic                          dec_err;
   logic [REG_W-1:0]              dec_rdata;

   irqfan_raw_tracker #(
      .NUM_LINES  (NUM_LINES),
      .LEGACY_BIT (LEGACY_BIT)
   ) u_raw (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_lines  (dev_lines),
      .legacy_irq (legacy_irq),
      .raw_q      (raw_q)
   );

   irqfan_mask_bank #(
      .NUM_CPUS (NUM_CPUS)
   ) u_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (mask_we),
      .wdata   (req_wdata),
      .masks_q (masks_q)
   );

   irqfan_reg_decode #(
      .NUM_CPUS (NUM_CPUS),
      .ADDR_W   (ADDR_W)
   ) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_bytes (req_bytes),
      .raw       (raw_q),
      .masks     (masks_q),
      .mask_we   (mask_we),
      .err       (dec_err),
      .rdata     (dec_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && dec_err;
         rsp_rdata <= req_valid ? dec_rdata : '0;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CPUS; c++) begin : g_irq
         always_ff @(posedge clk) begin
            if (!rst_n) cpu_irq[c] <= 1'b0;
            else        cpu_irq[c] <= |(masks_q[c] & raw_q);
         end

         AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (masks_q[c] == '0) |=> !cpu_irq[c]); // R3
      end
   endgenerate

   AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R11
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R11
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0)); // R9
   AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bytes != FULL_BYTES) |=> rsp_err); // R8
   AST_RO_WRITE_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(RAW_OFS)) |=> $stable(masks_q)); // R7

endmodule

// File: tb/irq_fanout_mask_bench.sv
`timescale 1ns/100ps
module irq_fanout_mask_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] dev_lines = '0;
   logic        legacy_irq = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [3:0]  req_bytes = 4'd8;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [63:0] rsp_rdata;
   logic [3:0]  cpu_irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [64:0] exp_q[$];
   string       tag_q[$];
   logic [63:0] m_mask[4];

   always #2.5 clk = ~clk;

   irq_fanout_mask u_irq_fanout_mask (
      .clk(clk), .rst_n(rst_n), .dev_lines(dev_lines), .legacy_irq(legacy_irq),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_bytes(req_bytes), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq)
   );

   function automatic logic [11:0] mofs(input int c);
      return (c < 2 ? 12'h200 : 12'h600) + (c % 2 != 0 ? 12'h040 : 12'h000);
   endfunction

   function automatic logic [63:0] raw_exp();
      logic [63:0] r;
      r = dev_lines;
      r[55] = r[55] | legacy_irq;
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: one expected response popped per observed response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(0, "R11 unexpected response", {rsp_err, rsp_rdata}, '0);
         end else begin
            logic [64:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({rsp_err, rsp_rdata} === e, t, {rsp_err, rsp_rdata}, e);
         end
      end
   end

   task automatic access(input logic wr, input logic [11:0] a, input logic [3:0] nb,
                         input logic [63:0] wd, input logic e_err, input logic [63:0] e_d,
                         input string tag);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = nb; req_wdata = wd;
      exp_q.push_back({e_err, e_d});
      tag_q.push_back(tag);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_bytes = 4'd8;
   endtask

   task automatic wr_mask(input int c, input logic [63:0] v);
      access(1, mofs(c), 4'd8, v, 0, 64'd0, "R4 mask write");
      m_mask[c] = v;
   endtask

   task automatic check_irq(input string tag);
      for (int c = 0; c < 4; c++)
         check(cpu_irq[c] === |(m_mask[c] & raw_exp()), tag, {64'd0, cpu_irq[c]}, {64'd0, |(m_mask[c] & raw_exp())});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      check(cpu_irq === 4'b0, "R10 irq after reset", {61'd0, cpu_irq}, '0);
      check(rsp_valid === 1'b0, "R10 no response after reset", {64'd0, rsp_valid}, '0);
      for (int c = 0; c < 4; c++) access(0, mofs(c), 4'd8, 0, 0, 64'd0, "R10 mask resets to zero");
      access(0, 12'h300, 4'd8, 0, 0, 64'd0, "R10 raw resets to zero");

      // R4: masks store all bits
      wr_mask(0, 64'hFFFF_0000_0000_0001);
      wr_mask(1, 64'h8000_0000_0000_0F00);
      wr_mask(2, 64'h0080_0000_0000_0000);
      wr_mask(3, 64'hDEAD_BEEF_CAFE_F00D);
      for (int c = 0; c < 4; c++) access(0, mofs(c), 4'd8, 0, 0, m_mask[c], "R4 mask readback");

      // R1/R3: line change reaches irq two edges later
      dev_lines = 64'h0000_0000_0000_0001;
      @(posedge clk); @(negedge clk);
      check(cpu_irq[0] === 1'b0, "R3 irq not yet after one edge", {64'd0, cpu_irq[0]}, '0);
      @(posedge clk); @(negedge clk);
      check_irq("R3 irq after line rise");
      access(0, 12'h300, 4'd8, 0, 0, raw_exp(), "R1 R6 raw read");

      dev_lines = 64'h8000_0000_0000_0A00;
      repeat (2) @(posedge clk); @(negedge clk);
      check_irq("R3 irq pattern two");
      access(0, 12'h300, 4'd8, 0, 0, raw_exp(), "R1 R6 raw read two");
      for (int c = 0; c < 4; c++) access(0, mofs(c) + 12'h080, 4'd8, 0, 0, m_mask[c] & raw_exp(), "R5 view read");

      // R1: line falling clears the bit
      dev_lines = '0;
      repeat (2) @(posedge clk); @(negedge clk);
      check_irq("R1 R3 irq after lines fall");
      access(0, 12'h300, 4'd8, 0, 0, 64'd0, "R1 raw cleared");

      // R2: legacy input drives bit 55
      legacy_irq = 1'b1;
      repeat (2) @(posedge clk); @(negedge clk);
      check(cpu_irq[2] === 1'b1, "R2 legacy reaches cpu2", {64'd0, cpu_irq[2]}, 65'd1);
      access(0, 12'h300, 4'd8, 0, 0, 64'h0080_0000_0000_0000, "R2 raw bit 55");
      access(0, 12'h680, 4'd8, 0, 0, 64'h0080_0000_0000_0000, "R2 R5 cpu2 view");

      // R3: mask write clears irq one edge after the response
      wr_mask(2, 64'd0);
      @(posedge clk); @(negedge clk);
      check_irq("R3 irq after mask clear");
      legacy_irq = 1'b0;

      // R7: writes to read-only offsets ignored
      dev_lines = 64'h0000_0000_0000_0F01;
      repeat (2) @(posedge clk); @(negedge clk);
      access(1, 12'h300, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd0, "R7 raw write response");
      access(1, 12'h280, 4'd8, 64'd0, 0, 64'd0, "R7 view write response");
      access(1, 12'h6C0, 4'd8, 64'd0, 0, 64'd0, "R7 view3 write response");
      access(0, 12'h300, 4'd8, 0, 0, raw_exp(), "R7 raw unchanged");
      for (int c = 0; c < 4; c++) access(0, mofs(c), 4'd8, 0, 0, m_mask[c], "R7 masks unchanged");

      // R8: narrow accesses rejected
      access(1, 12'h200, 4'd4, 64'h1234, 1, 64'd0, "R8 narrow write error");
      access(0, 12'h200, 4'd4, 0, 1, 64'd0, "R8 narrow read error");
      access(0, 12'h200, 4'd8, 0, 0, m_mask[0], "R8 mask unchanged");

      // R9: unlisted offsets
      access(0, 12'h340, 4'd8, 0, 1, 64'd0, "R9 unlisted read");
      access(0, 12'h208, 4'd8, 0, 1, 64'd0, "R9 misaligned read");
      access(1, 12'h000, 4'd8, 64'hFF, 1, 64'd0, "R9 unlisted write");
      check_irq("R3 irq final");

      repeat (3) @(posedge clk); @(negedge clk);
      check(exp_q.size() == 0, "R11 all responses seen", {33'd0, 32'(exp_q.size())}, '0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule